// File: doc/BRIEF.md
# Two-Byte Result Serializer with Offset Trim

This block takes signed conversion results from a stream input and sends each one out over an 8-bit bus as a pair of bytes. Before a result goes out, the block limits it to the signed 16-bit range. It can subtract a stored zero offset from it, and it encodes it in one of two complemented codes. A single strobe pulse frames each byte pair. The first byte is valid at the strobe's rising edge and the second byte is valid at its falling edge.

The offset trim is controlled by one level input. When the level is raised, the next pair to start stores its own value as the offset, and that pair is shown uncorrected. Every pair after it has the offset subtracted for as long as the level stays high. Dropping the level empties the offset store. The producer side uses valid/ready with a single holding slot. A result may arrive while a pair is still on the bus, and it waits in the slot until that pair ends. While the slot is occupied, ready is low, and the producer must hold valid and data until a cycle in which both are high.

Top module: `word_byte_serializer`

## Requirements
- R1: After reset, bus_data is 00h, data_strobe is low and in_ready is high.
- R2: With fmt_sel low, the 16-bit code is the bitwise inverse of the signed value. So -32768 gives 7FFFh, 0 gives FFFFh and +32767 gives 8000h.
- R3: With fmt_sel high, the code is the R2 code with bit 15 inverted. So -32768 gives FFFFh, +32767 gives 0000h, 0 gives 7FFFh and -1 gives 8000h.
- R4: An input outside the signed 16-bit range is clamped to -32768 or +32767 before encoding. The result of the offset subtraction is clamped to that range in the same way, and it never wraps.
- R5: byte_order, fmt_sel and the value are sampled when a pair starts. With byte_order high, the first byte is code bits 7:0 and the second is bits 15:8. With byte_order low, the two are swapped.
- R6: A pair takes four cycles. In the first cycle the first byte is on the bus with the strobe low. In the second cycle the strobe rises and the first byte stays on the bus. In the third cycle the second byte appears while the strobe is still high. In the fourth cycle the strobe falls and the second byte stays. Each strobe pulse is exactly two cycles high, and the bus keeps the last second byte while idle.
- R7: in_ready is high exactly when the holding slot is empty. A transfer happens in a cycle with in_valid and in_ready both high, and ready is low in the cycle after a transfer. A result accepted during a pair is sent immediately after that pair ends, in arrival order.
- R8: Suppose az_en is high and no offset is stored. The next pair that starts stores its clamped input as the offset, and it is shown uncorrected.
- R9: While az_en stays high after a capture, each later pair shows the clamped input minus the offset. An input equal to the offset reads FFFFh with fmt_sel low and 7FFFh with fmt_sel high.
- R10: az_en low empties the offset store and takes effect for a pair starting in that same cycle. Pairs are then uncorrected, and raising az_en again captures a fresh offset.
- R11: No capture happens for any pair that starts on or before the clock edge that ends the first pair after reset.
- R12: With out_en low, bus_data reads 00h and bus_drv is low. The strobe, the ready signal and the pair sequence are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer has a result |
| in_ready | output | 1 | Holding slot is empty |
| in_data | input | IN_W (18) | Signed result, may exceed 16-bit range |
| byte_order | input | 1 | High: low byte first; low: high byte first |
| fmt_sel | input | 1 | Low: inverted two's complement; high: inverted offset binary |
| az_en | input | 1 | Offset trim level |
| out_en | input | 1 | Bus enable |
| bus_data | output | CODE_W/2 (8) | Byte bus, 00h while disabled |
| bus_drv | output | 1 | High when the bus is driven |
| data_strobe | output | 1 | Rises for the first byte, falls for the second |

## Verification
On every cycle, the assertions check the strobe pulse width and that the bus holds still across both strobe edges. They also check that ready drops after each transfer and that a disabled bus reads zero. Only the bench's scenarios can show the code values of each format, the clamping at both ends, the byte swap, and the offset rules: capture on the first pair, subtraction with clamping, clearing on a low level, and the blocked capture just after reset. These depend on which values were sent and in what order.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } fmt_e;

  // PH_FALL doubles as the idle phase so the last second byte stays visible
  typedef enum logic [1:0] {
    PH_SETUP  = 2'd0,
    PH_RISE   = 2'd1,
    PH_SECOND = 2'd2,
    PH_FALL   = 2'd3
  } phase_e;
endpackage

// File: rtl/wbs_intake.sv
`timescale 1ns/1ps
module wbs_intake #(
  parameter int IN_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  input  logic                   take,
  output logic                   held_valid,
  output logic signed [IN_W-1:0] held_data
);
  logic full_q;
  logic signed [IN_W-1:0] data_q;

  assign in_ready   = !full_q;
  assign held_valid = full_q;
  assign held_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wbs_offset.sv
`timescale 1ns/1ps
module wbs_offset #(
  parameter int IN_W   = 18,
  parameter int CODE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     az_en,
  input  logic                     first_done,
  input  logic                     load,
  input  logic signed [IN_W-1:0]   raw,
  output logic signed [CODE_W-1:0] corrected
);
  localparam logic signed [CODE_W-1:0] MAXV = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic signed [CODE_W-1:0] MINV = {1'b1, {(CODE_W-1){1'b0}}};

  logic signed [CODE_W-1:0] clamped;
  logic signed [CODE_W-1:0] off_q;
  logic                     held_q;
  logic signed [CODE_W-1:0] eff_off;
  logic signed [CODE_W:0]   diff;

  generate
    if (IN_W > CODE_W) begin : g_clamp
      localparam logic signed [IN_W-1:0] HI = IN_W'((2 ** (CODE_W - 1)) - 1);
      localparam logic signed [IN_W-1:0] LO = ~HI;
      always_comb begin
        if (raw > HI)      clamped = MAXV;
        else if (raw < LO) clamped = MINV;
        else               clamped = raw[CODE_W-1:0];
      end
    end else begin : g_pass
      assign clamped = raw;
    end
  endgenerate

  // a falling level already removes the trim for a pair starting this cycle
  assign eff_off = az_en ? off_q : '0;
  assign diff    = {clamped[CODE_W-1], clamped} - {eff_off[CODE_W-1], eff_off};

  always_comb begin
    if (diff[CODE_W] != diff[CODE_W-1])
      corrected = diff[CODE_W] ? MINV : MAXV;
    else
      corrected = diff[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      held_q <= 1'b0;
    end else if (!az_en) begin
      off_q  <= '0;
      held_q <= 1'b0;
    end else if (load && first_done && !held_q) begin
      off_q  <= clamped;
      held_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wbs_encoder.sv
`timescale 1ns/1ps
module wbs_encoder
  import wbs_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  fmt_e                     fmt,
  input  logic signed [CODE_W-1:0] value,
  output logic        [CODE_W-1:0] code
);
  logic [CODE_W-1:0] inv;
  assign inv = ~value;

  always_comb begin
    code = inv;
    if (fmt == FMT_OFFSET) code[CODE_W-1] = ~inv[CODE_W-1];
  end
endmodule

// File: rtl/wbs_sequencer.sv
`timescale 1ns/1ps
module wbs_sequencer
  import wbs_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                held_valid,
  input  logic [CODE_W-1:0]   code_in,
  input  logic                lo_first_in,
  output logic                take,
  output logic                first_done,
  output logic [CODE_W/2-1:0] byte_out,
  output logic                strobe
);
  localparam int BYTE_W = CODE_W / 2;

  logic              busy_q;
  phase_e            ph_q;
  logic [CODE_W-1:0] word_q;
  logic              lo_first_q;
  logic              done_q;
  logic [BYTE_W-1:0] lo_byte, hi_byte;
  logic              show_first;

  assign take       = held_valid && (!busy_q || ph_q == PH_FALL);
  assign first_done = done_q;
  assign lo_byte    = word_q[BYTE_W-1:0];
  assign hi_byte    = word_q[CODE_W-1:BYTE_W];
  assign show_first = busy_q && (ph_q == PH_SETUP || ph_q == PH_RISE);
  assign strobe     = busy_q && (ph_q == PH_RISE || ph_q == PH_SECOND);

  always_comb begin
    if (show_first) byte_out = lo_first_q ? lo_byte : hi_byte;
    else            byte_out = lo_first_q ? hi_byte : lo_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      ph_q       <= PH_FALL;
      word_q     <= '0;
      lo_first_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (busy_q && ph_q == PH_FALL) done_q <= 1'b1;
      if (take) begin
        busy_q     <= 1'b1;
        ph_q       <= PH_SETUP;
        word_q     <= code_in;
        lo_first_q <= lo_first_in;
      end else if (busy_q) begin
        case (ph_q)
          PH_SETUP:  ph_q <= PH_RISE;
          PH_RISE:   ph_q <= PH_SECOND;
          PH_SECOND: ph_q <= PH_FALL;
          default:   busy_q <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/word_byte_serializer.sv
`timescale 1ns/1ps
module word_byte_serializer
  import wbs_pkg::*;
#(
  parameter int IN_W   = 18,
  parameter int CODE_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  input  logic                   byte_order,
  input  logic                   fmt_sel,
  input  logic                   az_en,
  input  logic                   out_en,
  output logic [CODE_W/2-1:0]    bus_data,
  output logic                   bus_drv,
  output logic                   data_strobe
);
  localparam int BYTE_W = CODE_W / 2;

  logic                     held_valid;
  logic signed [IN_W-1:0]   held_data;
  logic                     take;
  logic                     first_done;
  logic signed [CODE_W-1:0] corrected;
  logic [CODE_W-1:0]        code;
  logic [BYTE_W-1:0]        seq_byte;

  wbs_intake #(.IN_W(IN_W)) u_intake (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .take(take), .held_valid(held_valid), .held_data(held_data)
  );

  wbs_offset #(.IN_W(IN_W), .CODE_W(CODE_W)) u_offset (
    .clk(clk), .rst_n(rst_n), .az_en(az_en), .first_done(first_done),
    .load(take), .raw(held_data), .corrected(corrected)
  );

  wbs_encoder #(.CODE_W(CODE_W)) u_encoder (
    .fmt(fmt_e'(fmt_sel)), .value(corrected), .code(code)
  );

  wbs_sequencer #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .held_valid(held_valid), .code_in(code),
    .lo_first_in(byte_order), .take(take), .first_done(first_done),
    .byte_out(seq_byte), .strobe(data_strobe)
  );

  assign bus_data = out_en ? seq_byte : '0;
  assign bus_drv  = out_en;
endmodule

// File: rtl/wbs_checker.sv
`timescale 1ns/1ps
module wbs_checker #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_en,
  input logic [BW-1:0] bus_data,
  input logic          bus_drv,
  input logic          data_strobe
);
  // R6
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_strobe) |=> data_strobe);

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_strobe && $past(data_strobe)) |=> !data_strobe);

  // R6
  rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_strobe) && out_en && $past(out_en)) |-> $stable(bus_data));

  // R6
  fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(data_strobe) && out_en && $past(out_en)) |-> $stable(bus_data));

  // R7
  slot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R12
  bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (bus_data == '0 && !bus_drv));
endmodule

bind word_byte_serializer wbs_checker #(.BW(CODE_W/2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_en(out_en), .bus_data(bus_data), .bus_drv(bus_drv),
  .data_strobe(data_strobe)
);

// File: tb/word_byte_serializer_bench.sv
`timescale 1ns/1ps
module word_byte_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [17:0] in_data = '0;
  logic byte_order = 1'b1;
  logic fmt_sel = 1'b0;
  logic az_en = 1'b0;
  logic out_en = 1'b1;
  logic [7:0] bus_data;
  logic bus_drv;
  logic data_strobe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  word_byte_serializer u_word_byte_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .byte_order(byte_order), .fmt_sel(fmt_sel),
    .az_en(az_en), .out_en(out_en), .bus_data(bus_data), .bus_drv(bus_drv),
    .data_strobe(data_strobe)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mq[$];
  int m_busy, m_ph, m_word, m_lo, m_first, m_held, m_off;
  int t_raw, t_c, t_v, t_code, t_old_first;
  bit t_take, t_acc;

  function automatic int clamp16(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_busy = 0; m_ph = 3; m_word = 0; m_lo = 0;
      m_first = 0; m_held = 0; m_off = 0;
    end else begin
      t_take = (mq.size() != 0) && (m_busy == 0 || m_ph == 3);
      t_acc  = in_valid && (mq.size() == 0);
      t_old_first = m_first;
      if (m_busy != 0 && m_ph == 3) m_first = 1;
      if (t_take) begin
        t_raw  = mq.pop_front();
        t_c    = clamp16(t_raw);
        t_v    = clamp16(t_c - (az_en ? m_off : 0));
        t_code = (~t_v) & 16'hFFFF;
        if (fmt_sel) t_code = t_code ^ 16'h8000;
        m_word = t_code; m_lo = byte_order; m_busy = 1; m_ph = 0;
        if (az_en && t_old_first != 0 && m_held == 0) begin
          m_off = t_c; m_held = 1;
        end
      end else if (m_busy != 0 && m_ph < 3) m_ph = m_ph + 1;
      else m_busy = 0;
      if (!az_en) begin m_off = 0; m_held = 0; end
      if (t_acc) mq.push_back(int'(in_data));
    end
  end

  int e_strobe, e_byte, e_bus, e_ready;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      e_strobe = (m_busy != 0 && (m_ph == 1 || m_ph == 2)) ? 1 : 0;
      if (m_busy != 0 && m_ph < 2) e_byte = m_lo ? (m_word & 255) : (m_word >> 8);
      else                         e_byte = m_lo ? (m_word >> 8) : (m_word & 255);
      e_bus   = out_en ? e_byte : 0;
      e_ready = (mq.size() == 0) ? 1 : 0;
      chk(int'(data_strobe) == e_strobe, "R6 strobe", int'(data_strobe), e_strobe);
      chk(int'(bus_data) == e_bus, "R6 bus byte", int'(bus_data), e_bus);
      chk(int'(in_ready) == e_ready, "R7 ready", int'(in_ready), e_ready);
      chk(bus_drv == out_en, "R12 drive", int'(bus_drv), int'(out_en));
    end
  end

  // ---------------- bus monitor ----------------
  logic [15:0] rxq[$];
  logic prev_s = 0;
  logic [7:0] b0 = 0;
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s = 0; hi_cnt = 0;
    end else begin
      if (data_strobe && !prev_s) b0 = bus_data;
      if (data_strobe) hi_cnt++;
      if (!data_strobe && prev_s) begin
        rxq.push_back({b0, bus_data});
        chk(hi_cnt == 2, "R6 pulse width", hi_cnt, 2);
        hi_cnt = 0;
      end
      prev_s = data_strobe;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; in_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rxq.delete();
  endtask

  task automatic send(int v);
    @(posedge clk); #1;
    while (!in_ready) begin @(posedge clk); #1; end
    in_data = 18'(v);
    in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0;
    chk(!in_ready, "R7 slot full after transfer", int'(in_ready), 0);
  endtask

  task automatic expect_pair(logic [15:0] code, string tag);
    logic [15:0] got, exp;
    int t = 0;
    while (rxq.size() == 0 && t < 200) begin @(negedge clk); t++; end
    exp = byte_order ? {code[7:0], code[15:8]} : code;
    if (rxq.size() == 0) begin
      chk(0, {tag, " no pair"}, 0, int'(exp));
    end else begin
      got = rxq.pop_front();
      chk(got == exp, tag, int'(got), int'(exp));
    end
  endtask

  task automatic set_ctl(bit ord, bit fmt, bit az, bit oe);
    @(posedge clk); #1;
    byte_order = ord; fmt_sel = fmt; az_en = az; out_en = oe;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(bus_data == 8'h00, "R1 bus", int'(bus_data), 0);
    chk(!data_strobe, "R1 strobe", int'(data_strobe), 0);
    chk(in_ready, "R1 ready", int'(in_ready), 1);

    // R2 inverted two's complement, low byte first
    set_ctl(1, 0, 0, 1);
    send(-32768); expect_pair(16'h7FFF, "R2 neg full scale");
    send(0);      expect_pair(16'hFFFF, "R2 zero");
    send(32767);  expect_pair(16'h8000, "R2 pos full scale");

    // R3 inverted offset binary
    set_ctl(1, 1, 0, 1);
    send(-32768); expect_pair(16'hFFFF, "R3 neg full scale");
    send(32767);  expect_pair(16'h0000, "R3 pos full scale");
    send(0);      expect_pair(16'h7FFF, "R3 zero");
    send(-1);     expect_pair(16'h8000, "R3 minus one");

    // R4 input clamping
    set_ctl(1, 0, 0, 1);
    send(100000);  expect_pair(16'h8000, "R4 clamp high");
    send(-100000); expect_pair(16'h7FFF, "R4 clamp low");

    // R5 high byte first
    set_ctl(0, 0, 0, 1);
    send(16'h1234); expect_pair(16'hEDCB, "R5 swapped order");

    // R7 back-to-back through the holding slot
    set_ctl(1, 0, 0, 1);
    send(1); send(2);
    expect_pair(16'hFFFE, "R7 first of two");
    expect_pair(16'hFFFD, "R7 second of two");

    // R8 capture, R9 subtract, R4 clamp after subtract
    set_ctl(1, 0, 1, 1);
    send(500);    expect_pair(16'hFE0B, "R8 capture shown raw");
    send(500);    expect_pair(16'hFFFF, "R9 equal reads zero");
    set_ctl(1, 1, 1, 1);
    send(500);    expect_pair(16'h7FFF, "R9 equal reads midscale");
    set_ctl(1, 0, 1, 1);
    send(400);    expect_pair(16'h0063, "R9 minus offset");
    send(-32768); expect_pair(16'h7FFF, "R4 clamp after subtract");

    // R10 clear and recapture
    set_ctl(1, 0, 0, 1);
    send(500);    expect_pair(16'hFE0B, "R10 cleared");
    set_ctl(1, 0, 1, 1);
    send(200);    expect_pair(16'hFF37, "R10 recapture raw");
    send(200);    expect_pair(16'hFFFF, "R10 recaptured offset");

    // R12 bus disabled
    set_ctl(1, 0, 0, 0);
    send(7);      expect_pair(16'h0000, "R12 bus reads zero");
    chk(!bus_drv, "R12 drive low", int'(bus_drv), 0);
    set_ctl(1, 0, 0, 1);

    // R11 no capture on the first pair after reset
    az_en = 1;
    do_reset();
    send(300);  expect_pair(16'hFED3, "R11 first pair uncorrected");
    send(1000); expect_pair(16'hFC17, "R11 second pair captures");
    send(1000); expect_pair(16'hFFFF, "R11 offset from second pair");
    set_ctl(1, 0, 0, 1);

    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired (R7 stall) actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule